// File: doc/BRIEF.md
# Dual Timer/Counter Unit

This block holds two 16-bit timer/counters, each kept as a high byte and a low byte. A shared configuration register and a shared control register set them up. Each timer counts one of two sources: the system clock divided by a parameter (12 by default), or falling edges on its external count pin. An external gate pin can qualify the count. When a timer rolls over, it sets its overflow flag. Software or an acknowledge pulse clears the flag.

Software reaches all six registers through one byte-wide port. Writes take effect at the clock edge, and reads are combinational from the address. Four count structures are available:
- a 13-bit counter, with a 5-bit prescale held in the low byte;
- a plain 16-bit counter;
- an 8-bit counter that reloads from the high byte;
- a split mode that turns timer 0 into two independent 8-bit counters.

Top module: `dual_timer_unit`

## Requirements
- R1: With its source-select bit at 0, an enabled timer advances exactly once in every DIV consecutive clock cycles. The divided clock is free-running from reset.
- R2: With its source-select bit at 1, a timer advances once for each 1-to-0 change of its count pin. The pin is sampled once per divided-clock period, and its sample register resets to 0.
- R3: A timer advances only while its run bit is 1 and, at the same time, either its gate bit is 0 or its gate pin is 1. Otherwise its count holds.
- R4: Mode 0 (mode bits 00) is a 13-bit counter. Bits 4:0 of the low byte count, and the high byte increments when they pass 0x1F. Bits 7:5 of the low byte never change. Rolling over from high byte 0xFF with bits 4:0 at 0x1F sets the flag.
- R5: Mode 1 (01) counts {high, low} as 16 bits. The step from 0xFFFF to 0x0000 sets the flag.
- R6: Mode 2 (10) counts the low byte. The step from 0xFF loads the high byte into the low byte and sets the flag. The high byte is unchanged.
- R7: When timer 0 is in mode 3 (11), its two bytes count separately.
  - Its low byte is an 8-bit counter under timer 0's source, run and gate, and its wrap sets flag 0.
  - Its high byte counts divided-clock ticks whenever run bit 1 is set, and its wrap sets flag 1.
  - Timer 1 in mode 3 holds its count.
- R8: The registers are addressed as follows.
  - 0: timer 0 low byte. 1: timer 0 high byte. 2: timer 1 low byte. 3: timer 1 high byte.
  - 4: configuration register. Bits 7:4 configure timer 1 and bits 3:0 configure timer 0. Within each nibble the order is {gate, source-select, mode[1:0]}.
  - 5: control register. Bit 7 is flag 1, bit 6 is run 1, bit 5 is flag 0 and bit 4 is run 0. Bits 3:0 read as 0.
  - 6 and 7 read as 0.
- R9: A write to the control register sets or clears the flags directly. A one-cycle int_ack[i] pulse clears flag i. A rollover in the same cycle still sets the flag.
- R10: A write to either count byte of a timer takes priority over that timer's count step in the same cycle.
- R11: After reset, all registers read 0 and both flags are 0.
- R12: While timer 0 is in mode 3, a rollover of timer 1 does not set flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| cnt_pin | input | 2 | External count pins, one per timer |
| gate_pin | input | 2 | External gate pins, one per timer |
| int_ack | input | 2 | Flag-clear pulses, one per timer |
| ovf_flag | output | 2 | Overflow flags, one per timer |

## Verification
The assertions assume that the count, gate and acknowledge pins are synchronous to clk and that the bus writes at most one register per cycle. The bench drives every input at the falling clock edge. Count pins are held at each level for two divided-clock periods, so that every fall is sampled exactly once. Counting windows are opened and closed with the gate pin, and each window spans a whole multiple of DIV cycles. This makes the expected count independent of the divider's phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 5;

  localparam logic [2:0] A_T0_LO = 3'd0;
  localparam logic [2:0] A_T0_HI = 3'd1;
  localparam logic [2:0] A_T1_LO = 3'd2;
  localparam logic [2:0] A_T1_HI = 3'd3;
  localparam logic [2:0] A_CFG   = 3'd4;
  localparam logic [2:0] A_CTL   = 3'd5;

  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
    logic              wrap;
  } tmr_next_t;

  // Next count for one step of the main counter path in each mode.
  function automatic tmr_next_t tmr_step(input tmr_mode_e m,
                                         input logic [BYTE_W-1:0] hi,
                                         input logic [BYTE_W-1:0] lo);
    tmr_next_t r;
    logic [PRE_W-1:0] pre;
    r = '0;
    pre = lo[PRE_W-1:0];
    case (m)
      MODE_13: begin
        r.lo   = {lo[BYTE_W-1:PRE_W], pre + 1'b1};
        r.hi   = (&pre) ? hi + 1'b1 : hi;
        r.wrap = (&pre) && (&hi);
      end
      MODE_16: begin
        {r.hi, r.lo} = {hi, lo} + 1'b1;
        r.wrap       = (&hi) && (&lo);
      end
      MODE_RELOAD: begin
        r.hi   = hi;
        r.lo   = (&lo) ? hi : lo + 1'b1;
        r.wrap = &lo;
      end
      default: begin
        r.hi   = hi;
        r.lo   = lo + 1'b1;
        r.wrap = &lo;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
    end
  endgenerate
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [N-1:0] pin,
  output logic [N-1:0] fall
);
  logic [N-1:0] samp_q;

  assign fall = {N{tick}} & samp_q & ~pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    samp_q <= '0;
    else if (tick) samp_q <= pin;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode,
  input  logic              step_en,
  input  logic              hi_step_en,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo,
  output logic [BYTE_W-1:0] hi,
  output logic              wrap,
  output logic              hi_wrap
);
  tmr_next_t nxt;
  logic      wr_any;
  logic      split;

  assign nxt     = tmr_step(mode, hi, lo);
  assign wr_any  = wr_lo | wr_hi;
  assign split   = (mode == MODE_SPLIT);
  assign wrap    = step_en & ~wr_any & nxt.wrap;
  assign hi_wrap = hi_step_en & split & ~wr_any & (&hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else if (wr_any) begin
      if (wr_lo) lo <= wdata;
      if (wr_hi) hi <= wdata;
    end else begin
      if (step_en) begin
        lo <= nxt.lo;
        hi <= nxt.hi;
      end
      if (hi_step_en && split) hi <= hi + 1'b1;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en && !hi_step_en && !wr_lo && !wr_hi |=> $stable({hi, lo})); // R3
  AST_PRESCALE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && !wr_any && mode == MODE_13 && !(&lo[PRE_W-1:0]) |=> hi == $past(hi)); // R4
  AST_WIDE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && mode == MODE_16 |=> {hi, lo} == '0); // R5
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && mode == MODE_RELOAD |=> lo == $past(hi)); // R6
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> lo == $past(wdata)); // R10
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import tmr_pkg::*;
#(
  parameter int DIV = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [1:0] cnt_pin,
  input  logic [1:0] gate_pin,
  input  logic [1:0] int_ack,
  output logic [1:0] ovf_flag
);
  localparam int NT = 2;

  logic [7:0]        cfg_q;
  logic [NT-1:0]     run_q;
  logic [NT-1:0]     flag_q;
  logic              tick;
  logic [NT-1:0]     fall;
  logic [NT-1:0]     step_en, hi_step_en, wrap, hi_wrap, flag_set;
  logic [NT-1:0]     wr_lo, wr_hi;
  logic [BYTE_W-1:0] lo [NT];
  logic [BYTE_W-1:0] hi [NT];
  tmr_mode_e         mode [NT];
  logic              wr_cfg, wr_ctl, t0_split;

  assign wr_cfg   = bus_we && bus_addr == A_CFG;
  assign wr_ctl   = bus_we && bus_addr == A_CTL;
  assign t0_split = (mode[0] == MODE_SPLIT);

  tmr_prescale #(.DIV(DIV)) u_pre (.clk(clk), .rst_n(rst_n), .tick(tick));
  tmr_edge #(.N(NT)) u_edge (.clk(clk), .rst_n(rst_n), .tick(tick),
                             .pin(cnt_pin), .fall(fall));

  generate
    for (genvar i = 0; i < NT; i++) begin : g_tmr
      logic gate_b, src_b, src_sel;
      assign mode[i]  = tmr_mode_e'(cfg_q[4*i +: 2]);
      assign src_b    = cfg_q[4*i + 2];
      assign gate_b   = cfg_q[4*i + 3];
      assign src_sel  = src_b ? fall[i] : tick;
      assign wr_lo[i] = bus_we && bus_addr == 3'(2*i);
      assign wr_hi[i] = bus_we && bus_addr == 3'(2*i + 1);
      if (i == 0) begin : g_t0
        assign step_en[i]    = src_sel & run_q[i] & (~gate_b | gate_pin[i]);
        assign hi_step_en[i] = tick & run_q[1];
        assign flag_set[i]   = wrap[i];
      end else begin : g_tn
        assign step_en[i]    = src_sel & run_q[i] & (~gate_b | gate_pin[i])
                               & (mode[i] != MODE_SPLIT);
        assign hi_step_en[i] = 1'b0;
        assign flag_set[i]   = t0_split ? hi_wrap[0] : wrap[i];
      end
      tmr_core u_core (
        .clk(clk), .rst_n(rst_n), .mode(mode[i]),
        .step_en(step_en[i]), .hi_step_en(hi_step_en[i]),
        .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wdata(bus_wdata),
        .lo(lo[i]), .hi(hi[i]), .wrap(wrap[i]), .hi_wrap(hi_wrap[i]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_cfg) cfg_q <= bus_wdata;
      if (wr_ctl) begin
        run_q  <= {bus_wdata[6], bus_wdata[4]};
        flag_q <= {bus_wdata[7], bus_wdata[5]} | flag_set;
      end else begin
        flag_q <= (flag_q & ~int_ack) | flag_set;
      end
    end
  end

  assign ovf_flag = flag_q;

  always_comb begin
    case (bus_addr)
      A_T0_LO: bus_rdata = lo[0];
      A_T0_HI: bus_rdata = hi[0];
      A_T1_LO: bus_rdata = lo[1];
      A_T1_HI: bus_rdata = hi[1];
      A_CFG:   bus_rdata = cfg_q;
      A_CTL:   bus_rdata = {flag_q[1], run_q[1], flag_q[0], run_q[0], 4'b0000};
      default: bus_rdata = 8'h00;
    endcase
  end

  AST_FLAG0_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wrap[0] |=> ovf_flag[0]); // R9
  AST_FLAG1_SET: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set[1] |=> ovf_flag[1]); // R9
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack[0] && !wrap[0] && !wr_ctl |=> !ovf_flag[0]); // R9
  AST_SPLIT_NO_T1_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    t0_split && !hi_wrap[0] && !wr_ctl |=> !$rose(ovf_flag[1])); // R12
  AST_T1_SPLIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] == MODE_SPLIT && !wr_lo[1] && !wr_hi[1] |=> $stable({hi[1], lo[1]})); // R7
endmodule

// File: tb/dual_timer_unit_tb.sv
`timescale 1ns/1ps
module dual_timer_unit_tb;
  localparam int DIV = 12;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [1:0] cnt_pin = 0, gate_pin = 0, int_ack = 0;
  logic [1:0] ovf_flag;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dual_timer_unit #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .int_ack(int_ack), .ovf_flag(ovf_flag));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd16(input int t, output logic [15:0] v);
    logic [7:0] l, h;
    rd(3'(2*t), l);
    rd(3'(2*t+1), h);
    v = {h, l};
  endtask

  task automatic load16(input int t, input logic [15:0] v);
    wr(3'(2*t), v[7:0]);
    wr(3'(2*t+1), v[15:8]);
  endtask

  // Expected result of n count steps, computed arithmetically per mode.
  task automatic expect_run(input int m, input int init, input int n,
                            output int res, output int wrapped);
    int h, l, v;
    h = init / 256; l = init % 256; wrapped = 0;
    if (m == 0) begin
      v = h * 32 + (l % 32) + n;
      wrapped = (v >= 8192);
      v = v % 8192;
      res = (v / 32) * 256 + (l / 32) * 32 + (v % 32);
    end else if (m == 1) begin
      v = init + n;
      wrapped = (v >= 65536);
      res = v % 65536;
    end else begin
      for (int k = 0; k < n; k++) begin
        if (l == 255) begin l = h; wrapped = 1; end
        else l = l + 1;
      end
      res = h * 256 + l;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [15:0] v, w;
    int res, wrp;
    logic [15:0] pre [4];
    pre[0] = 16'h0000; pre[1] = 16'hFFFD; pre[2] = 16'h1FFE; pre[3] = 16'h80FB;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R11 reset reg", d, 0);
    end
    chk("R11 reset flags", ovf_flag, 0);

    // R8 configuration readback and control layout
    wr(3'd4, 8'hA5); rd(3'd4, d); chk("R8 cfg readback", d, 8'hA5);
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h0F); rd(3'd5, d); chk("R8 ctl low nibble", d, 8'h00);
    rd(3'd6, d); chk("R8 unused addr", d, 0);

    // R1 R4 R5 R6 sweep: gated windows of 5 ticks, every timer, mode and preload
    for (int t = 0; t < 2; t++) begin
      for (int m = 0; m < 3; m++) begin
        for (int p = 0; p < 4; p++) begin
          logic [3:0] nib;
          nib = {1'b1, 1'b0, 2'(m)};
          wr(3'd4, t == 0 ? {4'h0, nib} : {nib, 4'h0});
          load16(t, pre[p]);
          wr(3'd5, t == 0 ? 8'h10 : 8'h40);
          @(negedge clk);
          gate_pin[t] = 1;
          repeat (5 * DIV) @(negedge clk);
          gate_pin[t] = 0;
          rd16(t, v);
          expect_run(m, int'(pre[p]), 5, res, wrp);
          chk($sformatf("R%0s mode%0d timer%0d count", m == 0 ? "4" : m == 1 ? "5" : "6", m, t), v, res);
          chk("R1 R9 flag after window", ovf_flag[t], wrp);
          if (ovf_flag[t]) begin
            @(negedge clk); int_ack[t] = 1;
            @(negedge clk); int_ack[t] = 0;
            chk("R9 ack clears flag", ovf_flag[t], 0);
          end
          wr(3'd5, 8'h00);
        end
      end
    end

    // R3 gate low / run off: no count
    wr(3'd4, 8'h09); load16(0, 16'h0010); wr(3'd5, 8'h10);
    repeat (3 * DIV) @(negedge clk);
    rd16(0, v); chk("R3 gate pin low holds", v, 16'h0010);
    wr(3'd4, 8'h01); wr(3'd5, 8'h00);
    repeat (3 * DIV) @(negedge clk);
    rd16(0, v); chk("R3 run off holds", v, 16'h0010);

    // R9 control write clears a set flag
    wr(3'd4, 8'h01); load16(0, 16'hFFFF); wr(3'd5, 8'h10);
    repeat (2 * DIV) @(negedge clk);
    chk("R9 wrap sets flag", ovf_flag[0], 1);
    wr(3'd5, 8'h00);
    chk("R9 ctl write clears", ovf_flag[0], 0);

    // R2 external counting: 4 falls
    wr(3'd4, 8'h05); load16(0, 16'h0000); wr(3'd5, 8'h10);
    for (int k = 0; k < 4; k++) begin
      cnt_pin[0] = 1; repeat (2 * DIV) @(negedge clk);
      cnt_pin[0] = 0; repeat (2 * DIV) @(negedge clk);
    end
    rd16(0, v); chk("R2 external falls", v, 4);
    wr(3'd5, 8'h00);

    // R10 back-to-back writes suppress counting
    wr(3'd4, 8'h01); load16(0, 16'h0000); wr(3'd5, 8'h10);
    @(negedge clk);
    bus_we = 1; bus_addr = 3'd0; bus_wdata = 8'h40;
    repeat (3 * DIV) @(negedge clk);
    bus_we = 0;
    rd(3'd0, d); chk("R10 write wins", d, 8'h40);
    repeat (2 * DIV) @(negedge clk);
    rd(3'd0, d); chk("R10 count resumes", d, 8'h42);
    wr(3'd5, 8'h00);

    // R7 split mode, both halves wrap
    wr(3'd4, 8'h13); load16(0, 16'hFDFE); load16(1, 16'h0000);
    wr(3'd5, 8'h50);
    repeat (3 * DIV) @(negedge clk);
    rd(3'd0, d); chk("R7 split low byte", d, 8'h01);
    rd(3'd1, d); chk("R7 split high byte", d, 8'h00);
    chk("R7 flags", ovf_flag, 2'b11);
    rd16(1, v); chk("R7 timer1 still counts", v, 16'h0003);
    wr(3'd5, 8'h00);

    // R12 timer1 rollover hidden while timer0 split
    wr(3'd4, 8'h13); load16(0, 16'h0000); load16(1, 16'hFFFE);
    wr(3'd5, 8'h40);
    repeat (5 * DIV) @(negedge clk);
    rd16(1, v); chk("R12 timer1 count", v, 16'h0003);
    chk("R12 flag1 stays clear", ovf_flag[1], 0);
    rd16(0, w); chk("R12 split high ticks", w, 16'h0500);
    wr(3'd5, 8'h00);

    // R7 timer1 in mode 3 holds
    wr(3'd4, 8'h31); load16(1, 16'h1234); wr(3'd5, 8'h40);
    repeat (3 * DIV) @(negedge clk);
    rd16(1, v); chk("R7 timer1 mode3 hold", v, 16'h1234);
    wr(3'd5, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule